// File: doc/BRIEF.md
# Radio Mode Sequencer

This block sits on the host side of a simple FSK radio and drives its three digital control pins: power enable, transmit select and band select. The host asks for standby, receive or transmit on one of two bands. The block applies the matching pin levels and starts a settling timer. It lets host transmit data through to the radio data pin only after that timer has run out. It marks demodulated data as valid only after the same kind of wait.

The wait depends on the transition. Receive to transmit, transmit to receive, standby to receive and standby to transmit each have their own delay. The first activation after reset, which stands for a cold supply start, uses longer delays. A cold start into transmit also holds the transmit-select pin low until only the receive-to-transmit margin is left. A request that arrives during a wait aborts that wait and restarts the timer with the delay for the new transition. A band change while active is handled as a re-tune. An optional polling mode cycles the receiver between a short on window and a long off time.

All delays are parameters given in microseconds and are turned into clock cycles from a clock-frequency parameter.

Top module: `radio_mode_seq`

## Requirements
- R1: After reset, rf_pwr_on, rf_tx_sel, rf_band, rf_din, rx_data_out, tx_ready and rx_valid are all 0.
- R2: A standby request (req_mode 00) drives rf_pwr_on and rf_tx_sel to 0 and clears tx_ready and rx_valid on the clock edge that samples it.
- R3: rf_band follows the requested band on the edge that samples the request. Band 0 selects the 433.92 MHz channel and band 1 selects the 315.16 MHz channel.
- R4: Request codes are 00 standby, 01 receive, 10 transmit, and 11 is treated as standby. In receive, rf_pwr_on=1 and rf_tx_sel=0. In transmit, rf_pwr_on=1 and rf_tx_sel=1.
- R5: From settled standby, a receive request raises rx_valid exactly SB2RX cycles after the pins change.
- R6: From settled standby, a transmit request raises tx_ready exactly SB2TX cycles after the pins change.
- R7: Switching from receive to transmit raises tx_ready exactly RX2TX cycles after rf_tx_sel rises.
- R8: Switching from transmit to receive raises rx_valid exactly TX2RX cycles after rf_tx_sel falls.
- R9: The first activation after reset waits COLD_RX cycles for receive or COLD_TX cycles for transmit. In a cold transmit, rf_tx_sel stays 0 until RX2TX cycles remain. Later activations use the warm delays.
- R10: A new request during a wait aborts that wait. The timer restarts with the delay for the transition from the mode currently applied on the pins to the new mode.
- R11: rf_din equals tx_data_in registered while tx_ready is set, and 0 otherwise. rx_data_out equals rf_dout registered while rx_valid is set, and 0 otherwise.
- R12: A band change while receive or transmit is active clears both flags on the same edge and re-applies the standby-to-active delay for the current direction.
- R13: Repeating the request that is already applied has no effect on pins or flags.
- R14: With poll_en=1 and receive requested, the power pin is on for POLL_ON cycles out of every POLL_PER cycles, starting with the request edge. Each on window runs the normal receive settle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled on the clock edge |
| req_mode | input | 2 | Requested mode: 00 standby, 01 receive, 10 transmit, 11 standby |
| req_band | input | 1 | Requested band: 0 = 433.92 MHz, 1 = 315.16 MHz |
| poll_en | input | 1 | Enables duty-cycled receive polling |
| tx_data_in | input | 1 | Host transmit bit level |
| rx_data_out | output | 1 | Gated received bit level |
| tx_ready | output | 1 | Transmit path settled; data is passed to the radio |
| rx_valid | output | 1 | Receive path settled; rx_data_out is meaningful |
| rf_pwr_on | output | 1 | Radio power enable pin |
| rf_tx_sel | output | 1 | Radio transmit select pin |
| rf_band | output | 1 | Radio band select pin |
| rf_din | output | 1 | Radio modulator data pin |
| rf_dout | input | 1 | Radio demodulator data pin |

## Verification
A wrong delay choice shows as a tx_ready or rx_valid edge that lands some cycles away from the exact count measured from the pin change. For that reason every settle is sampled one cycle before and exactly at its expected end. A cold flag that stays set, or one that clears too early, shows up at the next activation as a wait of the wrong length. A stuck internal mode or band register shows at once on the radio pins, or as a flag that is not cleared on the edge of a re-tune or abort. A poll counter that is off by any amount moves the fall or the rise of the power pin away from the window boundary.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;

  typedef enum logic [1:0] {
    MODE_STBY = 2'd0,
    MODE_RX   = 2'd1,
    MODE_TX   = 2'd2
  } rmode_e;

  // Request code to mode; the unused code falls back to standby.
  function automatic rmode_e decode_req(input logic [1:0] code);
    case (code)
      2'd1:    decode_req = MODE_RX;
      2'd2:    decode_req = MODE_TX;
      default: decode_req = MODE_STBY;
    endcase
  endfunction

  function automatic int max2(input int a, input int b);
    max2 = (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/radio_seq_delay.sv
module radio_seq_delay
  import radio_seq_pkg::*;
#(
  parameter int W         = 24,
  parameter int D_RX2TX   = 1,
  parameter int D_TX2RX   = 1,
  parameter int D_SB2RX   = 1,
  parameter int D_SB2TX   = 1,
  parameter int D_COLD_RX = 1,
  parameter int D_COLD_TX = 1
) (
  input  rmode_e         from_mode,
  input  rmode_e         to_mode,
  input  logic           cold,
  output logic [W-1:0]   delay,
  output logic           cold_tx
);

  always_comb begin
    delay   = W'(1);
    cold_tx = 1'b0;
    case (to_mode)
      MODE_RX: begin
        if (from_mode == MODE_TX)  delay = W'(D_TX2RX);
        else if (cold)             delay = W'(D_COLD_RX);
        else                       delay = W'(D_SB2RX);
      end
      MODE_TX: begin
        if (from_mode == MODE_RX)  delay = W'(D_RX2TX);
        else if (cold) begin
          delay   = W'(D_COLD_TX);
          cold_tx = 1'b1;
        end
        else                       delay = W'(D_SB2TX);
      end
      default: delay = W'(1);
    endcase
  end

endmodule

// File: rtl/radio_seq_timer.sv
module radio_seq_timer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         last
);

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign last = (cnt == W'(1));

endmodule

// File: rtl/radio_seq_poll.sv
module radio_seq_poll #(
  parameter int W   = 24,
  parameter int ON  = 2,
  parameter int PER = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic on_phase
);

  logic [W-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst || !active)               pcnt <= '0;
    else if (pcnt == W'(PER - 1))     pcnt <= '0;
    else                              pcnt <= pcnt + W'(1);
  end

  assign on_phase = active && (pcnt < W'(ON));

endmodule

// File: rtl/radio_mode_seq.sv
module radio_mode_seq
  import radio_seq_pkg::*;
#(
  parameter int CLK_HZ        = 50_000_000,
  parameter int T_RX2TX_US    = 1000,
  parameter int T_TX2RX_US    = 3000,
  parameter int T_SB2RX_US    = 3000,
  parameter int T_SB2TX_US    = 2000,
  parameter int T_COLD_TX_US  = 4000,
  parameter int T_COLD_RX_US  = 5000,
  parameter int T_POLL_ON_US  = 4000,
  parameter int T_POLL_PER_US = 200000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  input  logic       req_band,
  input  logic       poll_en,
  input  logic       tx_data_in,
  output logic       rx_data_out,
  output logic       tx_ready,
  output logic       rx_valid,
  output logic       rf_pwr_on,
  output logic       rf_tx_sel,
  output logic       rf_band,
  output logic       rf_din,
  input  logic       rf_dout
);

  localparam int CYC_US   = CLK_HZ / 1_000_000;
  localparam int C_RX2TX  = CYC_US * T_RX2TX_US;
  localparam int C_TX2RX  = CYC_US * T_TX2RX_US;
  localparam int C_SB2RX  = CYC_US * T_SB2RX_US;
  localparam int C_SB2TX  = CYC_US * T_SB2TX_US;
  localparam int C_COLDTX = CYC_US * T_COLD_TX_US;
  localparam int C_COLDRX = CYC_US * T_COLD_RX_US;
  localparam int C_PON    = CYC_US * T_POLL_ON_US;
  localparam int C_PPER   = CYC_US * T_POLL_PER_US;
  localparam int C_MAX    = max2(max2(max2(C_RX2TX, C_TX2RX), max2(C_SB2RX, C_SB2TX)),
                                 max2(max2(C_COLDTX, C_COLDRX), C_PPER));
  localparam int CW       = $clog2(C_MAX + 2);

  // Host intent
  rmode_e want_mode, want_mode_n, eff_mode, cur_mode, from_sel;
  logic   want_band, want_band_n, cur_band;

  // Sequencing state
  logic          cold, settling, hold_tx;
  logic          poll_active, poll_on;
  logic          mode_chg, band_chg, go_stby, go_act, finishing;
  logic          tx_ready_n, rx_valid_n;
  logic [CW-1:0] sel_delay, tmr_cnt;
  logic          sel_cold_tx, tmr_last;

  assign want_mode_n = req_valid ? decode_req(req_mode) : want_mode;
  assign want_band_n = req_valid ? req_band : want_band;
  assign poll_active = poll_en && (want_mode_n == MODE_RX);
  assign eff_mode    = (poll_active && !poll_on) ? MODE_STBY : want_mode_n;

  assign mode_chg  = (eff_mode != cur_mode);
  assign band_chg  = (want_band_n != cur_band);
  assign go_stby   = mode_chg && (eff_mode == MODE_STBY);
  assign go_act    = (eff_mode != MODE_STBY) && (mode_chg || band_chg);
  // A re-tune on the same direction is timed as if leaving standby.
  assign from_sel  = mode_chg ? cur_mode : MODE_STBY;
  assign finishing = settling && tmr_last && !go_act && !go_stby;

  radio_seq_poll #(.W(CW), .ON(C_PON), .PER(C_PPER)) i_poll (
    .clk      (clk),
    .rst      (rst),
    .active   (poll_active),
    .on_phase (poll_on)
  );

  radio_seq_delay #(
    .W(CW), .D_RX2TX(C_RX2TX), .D_TX2RX(C_TX2RX), .D_SB2RX(C_SB2RX),
    .D_SB2TX(C_SB2TX), .D_COLD_RX(C_COLDRX), .D_COLD_TX(C_COLDTX)
  ) i_delay (
    .from_mode (from_sel),
    .to_mode   (eff_mode),
    .cold      (cold),
    .delay     (sel_delay),
    .cold_tx   (sel_cold_tx)
  );

  radio_seq_timer #(.W(CW)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (go_act),
    .load_val (sel_delay),
    .cnt      (tmr_cnt),
    .last     (tmr_last)
  );

  always_comb begin
    tx_ready_n = tx_ready;
    rx_valid_n = rx_valid;
    if (go_stby || go_act) begin
      tx_ready_n = 1'b0;
      rx_valid_n = 1'b0;
    end else if (finishing) begin
      tx_ready_n = (cur_mode == MODE_TX);
      rx_valid_n = (cur_mode == MODE_RX);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      want_mode   <= MODE_STBY;
      want_band   <= 1'b0;
      cur_mode    <= MODE_STBY;
      cur_band    <= 1'b0;
      cold        <= 1'b1;
      settling    <= 1'b0;
      hold_tx     <= 1'b0;
      rf_pwr_on   <= 1'b0;
      rf_tx_sel   <= 1'b0;
      rf_band     <= 1'b0;
      tx_ready    <= 1'b0;
      rx_valid    <= 1'b0;
      rf_din      <= 1'b0;
      rx_data_out <= 1'b0;
    end else begin
      want_mode   <= want_mode_n;
      want_band   <= want_band_n;
      tx_ready    <= tx_ready_n;
      rx_valid    <= rx_valid_n;
      rf_din      <= tx_ready_n & tx_data_in;
      rx_data_out <= rx_valid_n & rf_dout;
      if (go_stby) begin
        cur_mode  <= MODE_STBY;
        cur_band  <= want_band_n;
        rf_band   <= want_band_n;
        rf_pwr_on <= 1'b0;
        rf_tx_sel <= 1'b0;
        settling  <= 1'b0;
        hold_tx   <= 1'b0;
      end else if (go_act) begin
        cur_mode  <= eff_mode;
        cur_band  <= want_band_n;
        rf_band   <= want_band_n;
        rf_pwr_on <= 1'b1;
        rf_tx_sel <= (eff_mode == MODE_TX) && !sel_cold_tx;
        hold_tx   <= sel_cold_tx;
        settling  <= 1'b1;
      end else begin
        if ((eff_mode == MODE_STBY) && band_chg) begin
          cur_band <= want_band_n;
          rf_band  <= want_band_n;
        end
        if (hold_tx && (tmr_cnt == CW'(C_RX2TX + 1))) begin
          rf_tx_sel <= 1'b1;
          hold_tx   <= 1'b0;
        end
        if (finishing) begin
          settling <= 1'b0;
          cold     <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/radio_mode_seq_chk.sv
module radio_mode_seq_chk (
  input logic clk,
  input logic rst,
  input logic rf_pwr_on,
  input logic rf_tx_sel,
  input logic rf_band,
  input logic tx_ready,
  input logic rx_valid,
  input logic rf_din,
  input logic rx_data_out
);

  // R2: no flag survives with the radio powered down
  assert_stby_flags_R2: assert property (@(posedge clk) disable iff (rst)
    !rf_pwr_on |-> (!tx_ready && !rx_valid));

  // R4: transmit readiness only with the transmit pin levels applied
  assert_tx_pins_R4: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (rf_pwr_on && rf_tx_sel));

  // R4: receive validity only with the receive pin levels applied
  assert_rx_pins_R4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (rf_pwr_on && !rf_tx_sel));

  // R7: transmit select is high at least one cycle before data is let through
  assert_tx_lead_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_ready) |-> $past(rf_tx_sel));

  // R7: a rising transmit select never comes with readiness on the same edge
  assert_no_instant_tx_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rf_tx_sel) |-> !tx_ready);

  // R11: idle data levels while the paths are not settled
  assert_din_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !tx_ready |-> !rf_din);

  assert_dout_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> !rx_data_out);

  // R12: a band change while powered drops both flags
  assert_retune_R12: assert property (@(posedge clk) disable iff (rst)
    (rf_pwr_on && (rf_band != $past(rf_band))) |-> (!tx_ready && !rx_valid));

endmodule

bind radio_mode_seq radio_mode_seq_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .rf_pwr_on   (rf_pwr_on),
  .rf_tx_sel   (rf_tx_sel),
  .rf_band     (rf_band),
  .tx_ready    (tx_ready),
  .rx_valid    (rx_valid),
  .rf_din      (rf_din),
  .rx_data_out (rx_data_out)
);

// File: tb/test_radio_mode_seq.sv
module test_radio_mode_seq;

  // Scaled timing: one cycle per microsecond
  localparam int RX2TX = 10, TX2RX = 32, SB2RX = 28, SB2TX = 20;
  localparam int COLDTX = 40, COLDRX = 50, PON = 60, PPER = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_mode = 2'd0;
  logic req_band = 1'b0;
  logic poll_en = 1'b0;
  logic tx_data_in = 1'b0;
  logic rf_dout = 1'b0;
  logic rx_data_out, tx_ready, rx_valid, rf_pwr_on, rf_tx_sel, rf_band, rf_din;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  radio_mode_seq #(
    .CLK_HZ(1_000_000), .T_RX2TX_US(RX2TX), .T_TX2RX_US(TX2RX),
    .T_SB2RX_US(SB2RX), .T_SB2TX_US(SB2TX), .T_COLD_TX_US(COLDTX),
    .T_COLD_RX_US(COLDRX), .T_POLL_ON_US(PON), .T_POLL_PER_US(PPER)
  ) i_radio_mode_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_band(req_band), .poll_en(poll_en), .tx_data_in(tx_data_in),
    .rx_data_out(rx_data_out), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rf_pwr_on(rf_pwr_on), .rf_tx_sel(rf_tx_sel), .rf_band(rf_band),
    .rf_din(rf_din), .rf_dout(rf_dout)
  );

  typedef struct packed {
    logic        issue;
    logic [1:0]  mode;
    logic        band;
    logic [15:0] wt;
    logic [4:0]  exp;   // {pwr, tx_sel, ready, valid, band}
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'd1, 1'b0, 16'(COLDRX-1), 5'b10000, 8'd9},  // R9 cold receive, not yet
    '{1'b0, 2'd0, 1'b0, 16'd1,         5'b10010, 8'd9},  // R9 cold receive valid
    '{1'b1, 2'd2, 1'b0, 16'(RX2TX-1),  5'b11000, 8'd7},  // R7
    '{1'b0, 2'd0, 1'b0, 16'd1,         5'b11100, 8'd7},  // R7
    '{1'b1, 2'd1, 1'b0, 16'(TX2RX-1),  5'b10000, 8'd8},  // R8
    '{1'b0, 2'd0, 1'b0, 16'd1,         5'b10010, 8'd8},  // R8
    '{1'b1, 2'd0, 1'b1, 16'd0,         5'b00001, 8'd2},  // R2 and R3
    '{1'b1, 2'd1, 1'b1, 16'(SB2RX-1),  5'b10001, 8'd5},  // R5 warm
    '{1'b0, 2'd0, 1'b0, 16'd1,         5'b10011, 8'd5},  // R5
    '{1'b1, 2'd1, 1'b0, 16'd0,         5'b10000, 8'd12}, // R12 re-tune
    '{1'b0, 2'd0, 1'b0, 16'(SB2RX-1),  5'b10000, 8'd12}, // R12
    '{1'b0, 2'd0, 1'b0, 16'd1,         5'b10010, 8'd12}, // R12
    '{1'b1, 2'd0, 1'b0, 16'd0,         5'b00000, 8'd2},  // R2
    '{1'b1, 2'd2, 1'b0, 16'(SB2TX-1),  5'b11000, 8'd6},  // R6
    '{1'b0, 2'd0, 1'b0, 16'd1,         5'b11100, 8'd6},  // R6
    '{1'b1, 2'd2, 1'b0, 16'd0,         5'b11100, 8'd13}, // R13 same request
    '{1'b1, 2'd3, 1'b0, 16'd0,         5'b00000, 8'd4}   // R4 code 11
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic req(input logic [1:0] m, input logic b);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_band = b;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wait_n(3);
    rst = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [6:0] all_outs();
    return {rf_pwr_on, rf_tx_sel, rf_band, rf_din, rx_data_out, tx_ready, rx_valid};
  endfunction

  initial begin
    do_reset();
    chk("R1 reset state", 32'(all_outs()), 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].issue) req(TBL[i].mode, TBL[i].band);
      wait_n(int'(TBL[i].wt));
      chk($sformatf("R%0d vector %0d", TBL[i].rq, i),
          32'({rf_pwr_on, rf_tx_sel, tx_ready, rx_valid, rf_band}), 32'(TBL[i].exp));
    end

    // R11: gating of the transmit path
    @(negedge clk); tx_data_in = 1'b1;
    @(negedge clk);
    chk("R11 din idle in standby", 32'(rf_din), 32'd0);
    req(2'd2, 1'b0);
    wait_n(SB2TX);
    chk("R11 din passes when ready", 32'({tx_ready, rf_din}), 32'b11);
    tx_data_in = 1'b0;
    @(negedge clk);
    chk("R11 din follows low", 32'(rf_din), 32'd0);
    // R11: gating of the receive path, after a transmit-to-receive turn
    rf_dout = 1'b1;
    req(2'd1, 1'b0);
    wait_n(TX2RX - 1);
    chk("R11 dout held idle", 32'({rx_valid, rx_data_out}), 32'b00);
    wait_n(1);
    chk("R11 dout passes when valid", 32'({rx_valid, rx_data_out}), 32'b11);
    rf_dout = 1'b0;
    @(negedge clk);
    chk("R11 dout follows low", 32'(rx_data_out), 32'd0);

    // R10: abort a receive settle with a transmit request
    req(2'd0, 1'b0);
    req(2'd1, 1'b0);
    wait_n(9);
    req(2'd2, 1'b0);
    wait_n(RX2TX - 1);
    chk("R10 aborted wait not done", 32'({rf_tx_sel, tx_ready, rx_valid}), 32'b100);
    wait_n(1);
    chk("R10 restarted wait done", 32'({rf_tx_sel, tx_ready, rx_valid}), 32'b110);

    // R14: duty-cycled receive polling
    req(2'd0, 1'b0);
    poll_en = 1'b1;
    req(2'd1, 1'b0);
    wait_n(SB2RX - 1);
    chk("R14 poll settle pending", 32'({rf_pwr_on, rx_valid}), 32'b10);
    wait_n(1);
    chk("R14 poll valid", 32'({rf_pwr_on, rx_valid}), 32'b11);
    wait_n(PON - 1 - SB2RX);
    chk("R14 window end-1", 32'(rf_pwr_on), 32'd1);
    wait_n(1);
    chk("R14 off phase", 32'({rf_pwr_on, rx_valid}), 32'b00);
    wait_n(PPER - PON - 1);
    chk("R14 period end-1", 32'(rf_pwr_on), 32'd0);
    wait_n(1);
    chk("R14 next window", 32'({rf_pwr_on, rx_valid}), 32'b10);
    poll_en = 1'b0;
    req(2'd0, 1'b0);

    // R9: cold transmit start after a fresh reset
    do_reset();
    chk("R1 reset again", 32'(all_outs()), 32'd0);
    req(2'd2, 1'b1);
    wait_n(COLDTX - RX2TX - 1);
    chk("R9 cold tx_sel held low", 32'({rf_pwr_on, rf_tx_sel, tx_ready}), 32'b100);
    wait_n(1);
    chk("R9 cold tx_sel raised", 32'({rf_pwr_on, rf_tx_sel, tx_ready}), 32'b110);
    wait_n(RX2TX - 1);
    chk("R9 cold tx not ready", 32'(tx_ready), 32'd0);
    wait_n(1);
    chk("R9 cold tx ready", 32'({tx_ready, rf_band}), 32'b11);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule